// File: doc/BRIEF.md
# Serial Byte Receiver with Head-Aligned Error Flags

This block takes an asynchronous serial line, finds each frame's start bit, and samples every bit near its centre using a 16x oversampling tick that comes from outside. A frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit, and one stop bit. Each byte it receives goes into a two-entry buffer. The consumer sees the oldest entry on the read data port and removes it with a one-cycle read strobe.

Each buffer entry keeps its own stop-bit fault bit and parity fault bit next to the data. A byte with a bad stop bit or a parity mismatch is still stored. Its sticky flag turns on only when that byte becomes the oldest entry, so software sees the flag together with the byte that caused it. If a frame finishes while both entries are full, the new byte is dropped and an overrun flag is set. All three flags stay set until their clear strobe is pulsed. An interrupt output is the OR of the flags that are enabled.

Top module: `uart_rx_errq`

## Requirements
- R1: After reset, `rd_valid`, all three error flags and `err_irq` are 0.
- R2: A frame is a low start bit, eight data bits sent least significant bit first, a parity bit only when `par_en`=1, and a stop bit. Each bit lasts 16 `tick` pulses. After the frame, the byte is on `rd_data` with `rd_valid`=1.
- R3: A low pulse on an idle line that is high again at the middle of the start bit is discarded, and no byte is stored.
- R4: With `par_en`=1, a parity bit that breaks even parity (`par_odd`=0) or odd parity (`par_odd`=1) over the data and parity bits sets `pe_flag`. With `par_en`=0, no parity bit is expected.
- R5: A stop bit sampled low sets `fe_flag`, and the byte is still stored.
- R6: If the buffer is empty, a byte's fault flag turns on in the same cycle the byte is stored. If one entry is already occupied, the flag turns on only when the earlier byte is read.
- R7: A frame that completes with both entries full and no read in that cycle sets `ov_flag` and is dropped. The stored bytes are unchanged.
- R8: A read strobe in the same cycle that a frame completes into a full buffer frees an entry. The new byte is accepted and `ov_flag` does not set.
- R9: A one-cycle pulse on `clr_fe`, `clr_pe` or `clr_ov` clears the matching flag. If a flag is both set and cleared in the same cycle, setting wins.
- R10: `err_irq` is high when any flag is set and enabled. `irq_en` bit 0 enables `fe_flag`, bit 1 enables `pe_flag`, and bit 2 enables `ov_flag`.
- R11: A read strobe while the buffer is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick | input | 1 | 16x oversampling tick, one cycle wide |
| par_en | input | 1 | Expect a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_stb | input | 1 | Remove the oldest byte |
| clr_fe | input | 1 | Clear `fe_flag` |
| clr_pe | input | 1 | Clear `pe_flag` |
| clr_ov | input | 1 | Clear `ov_flag` |
| irq_en | input | 3 | Interrupt enables: bit 0 for fe, bit 1 for pe, bit 2 for ov |
| rd_data | output | 8 | Oldest stored byte |
| rd_valid | output | 1 | Buffer is not empty |
| fe_flag | output | 1 | Sticky stop-bit fault flag |
| pe_flag | output | 1 | Sticky parity fault flag |
| ov_flag | output | 1 | Sticky overrun flag |
| err_irq | output | 1 | OR of the enabled flags |

## Verification
A frame can complete into a full buffer in the same clock edge that a read strobe removes the oldest entry. At that edge the overrun decision and the buffer shift happen together. To hit that edge, the bench first times a frame into an empty buffer and records at which cycle of the stop bit `rd_valid` rises. It then fills the buffer and pulses the read strobe exactly one cycle earlier in a frame with the same alignment. The result passes if `ov_flag` stays low and the two bytes left in the buffer are the second and third bytes, in that order.

// File: rtl/uart_rx_errq.sv
module uart_rx_errq #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          tick,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rd_stb,
  input  logic          clr_fe,
  input  logic          clr_pe,
  input  logic          clr_ov,
  input  logic [2:0]    irq_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          fe_flag,
  output logic          pe_flag,
  output logic          ov_flag,
  output logic          err_irq
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DW);
  localparam int EW   = DW + 2;
  localparam int MID  = OSR / 2 - 1;
  localparam int LAST = OSR - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t           st;
  logic [1:0]    rs;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;
  logic          pbit, par_used, odd_l;
  logic [EW-1:0] ent0, ent1;
  logic [1:0]    lvl;

  wire rx   = rs[1];
  wire done = tick && st == S_STOP && cnt == CW'(LAST);
  wire bad_par = par_used && (^sh ^ pbit ^ odd_l);
  wire [EW-1:0] incoming = {!rx, bad_par, sh};

  wire       pop    = rd_stb && lvl != 2'd0;
  wire       push   = done && (lvl != 2'd2 || pop);
  wire       ovr    = done && lvl == 2'd2 && !pop;
  wire [1:0] pos    = lvl - {1'b0, pop};
  wire       to_head = push && pos == 2'd0;
  wire       head_load = to_head || (pop && lvl == 2'd2);
  wire [EW-1:0] head_new = to_head ? incoming : ent1;

  assign rd_data  = ent0[DW-1:0];
  assign rd_valid = lvl != 2'd0;
  assign err_irq  = |({ov_flag, pe_flag, fe_flag} & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs       <= 2'b11;
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      pbit     <= 1'b0;
      par_used <= 1'b0;
      odd_l    <= 1'b0;
    end else begin
      rs <= {rs[0], rxd};
      if (tick) begin
        case (st)
          S_IDLE: if (!rx) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (cnt == CW'(MID)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rx ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
          S_DATA: if (cnt == CW'(LAST)) begin
            cnt  <= '0;
            sh   <= {rx, sh[DW-1:1]};
            bitn <= bitn + 1'b1;
            if (bitn == BW'(DW - 1)) begin
              st       <= par_en ? S_PAR : S_STOP;
              par_used <= par_en;
              odd_l    <= par_odd;
            end
          end else cnt <= cnt + 1'b1;
          S_PAR: if (cnt == CW'(LAST)) begin
            cnt  <= '0;
            pbit <= rx;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (cnt == CW'(LAST)) begin
            cnt <= '0;
            st  <= S_HOLD;
          end else cnt <= cnt + 1'b1;
          S_HOLD: if (rx) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent0    <= '0;
      ent1    <= '0;
      lvl     <= '0;
      fe_flag <= 1'b0;
      pe_flag <= 1'b0;
      ov_flag <= 1'b0;
    end else begin
      if (pop) ent0 <= ent1;
      if (push) begin
        if (pos == 2'd0) ent0 <= incoming;
        else             ent1 <= incoming;
      end
      lvl     <= lvl - {1'b0, pop} + {1'b0, push};
      fe_flag <= (fe_flag & ~clr_fe) | (head_load & head_new[DW+1]);
      pe_flag <= (pe_flag & ~clr_pe) | (head_load & head_new[DW]);
      ov_flag <= (ov_flag & ~clr_ov) | ovr;
    end
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl != 2'd3);
  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lvl == 2'd2 && !rd_stb) |=> (lvl == 2'd2 && $stable(rd_data) && ov_flag));
  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lvl == 2'd2 && rd_stb && !clr_ov) |=> ($stable(ov_flag) && lvl == 2'd2));
  assert_fe_at_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_flag) |-> rd_valid);
  assert_pe_at_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe_flag) |-> rd_valid);
  assert_ov_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ov_flag) |-> $past(clr_ov));
  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_valid && !done) |=> !rd_valid);
endmodule

// File: tb/uart_rx_errq_tb.sv
module uart_rx_errq_tb_top;
  logic clk = 0, rst_n = 0, rxd = 1, par_en = 0, par_odd = 0, rd_stb = 0;
  logic clr_fe = 0, clr_pe = 0, clr_ov = 0;
  logic [2:0] irq_en = 3'b000;
  logic [1:0] tcnt = 0;
  logic tick;
  logic [7:0] rd_data;
  logic rd_valid, fe_flag, pe_flag, ov_flag, err_irq;
  int total = 0, bad = 0, k0 = -1;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1'b1;
  assign tick = tcnt == 2'd3;

  uart_rx_errq dut_i (.clk, .rst_n, .rxd, .tick, .par_en, .par_odd, .rd_stb,
    .clr_fe, .clr_pe, .clr_ov, .irq_en, .rd_data, .rd_valid, .fe_flag,
    .pe_flag, .ov_flag, .err_irq);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pb, input logic sv, input int rd_at);
    do @(negedge clk); while (tcnt != 2'd0);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    if (par_en) bit_out(pb);
    rxd = sv;
    for (int j = 1; j <= 64; j++) begin
      @(negedge clk);
      rd_stb = (j == rd_at);
      if (rd_at == -1 && k0 < 0 && rd_valid) k0 = j;
    end
    rd_stb = 0;
    rxd = 1;
    repeat (64) @(negedge clk);
  endtask

  task automatic rd();
    @(negedge clk) rd_stb = 1;
    @(negedge clk) rd_stb = 0;
  endtask

  task automatic clr_all();
    @(negedge clk) begin clr_fe = 1; clr_pe = 1; clr_ov = 1; end
    @(negedge clk) begin clr_fe = 0; clr_pe = 0; clr_ov = 0; end
  endtask

  task automatic t_reset();
    chk(!rd_valid && !fe_flag && !pe_flag && !ov_flag && !err_irq, "R1 reset state",
        {rd_valid, fe_flag, pe_flag, ov_flag, err_irq}, 0);
  endtask

  task automatic t_basic();
    send(8'hA5, 0, 1, -1);
    chk(rd_valid && rd_data == 8'hA5, "R2 byte received", rd_data, 8'hA5);
    chk(!fe_flag && !pe_flag, "R2 no flags", {fe_flag, pe_flag}, 0);
    rd();
    chk(!rd_valid, "R2 buffer empty after read", rd_valid, 0);
  endtask

  task automatic t_false_start();
    do @(negedge clk); while (tcnt != 2'd0);
    rxd = 0;
    repeat (16) @(negedge clk);
    rxd = 1;
    repeat (800) @(negedge clk);
    chk(!rd_valid, "R3 glitch discarded", rd_valid, 0);
  endtask

  task automatic t_parity();
    par_en = 1; par_odd = 0;
    send(8'h03, 1'b0, 1, 0);
    chk(rd_valid && rd_data == 8'h03 && !pe_flag, "R4 even ok", pe_flag, 0);
    rd();
    send(8'h07, 1'b0, 1, 0);
    chk(rd_valid && rd_data == 8'h07 && pe_flag, "R4 even mismatch", pe_flag, 1);
    rd();
    @(negedge clk) clr_pe = 1;
    @(negedge clk) clr_pe = 0;
    chk(!pe_flag, "R9 pe cleared", pe_flag, 0);
    par_odd = 1;
    send(8'h07, 1'b0, 1, 0);
    chk(rd_data == 8'h07 && !pe_flag, "R4 odd ok", pe_flag, 0);
    rd();
    send(8'h03, 1'b0, 1, 0);
    chk(rd_data == 8'h03 && pe_flag, "R4 odd mismatch", pe_flag, 1);
    rd();
    clr_all();
    par_en = 0; par_odd = 0;
  endtask

  task automatic t_framing();
    send(8'h5C, 0, 0, 0);
    chk(rd_valid && rd_data == 8'h5C, "R5 errored byte stored", rd_data, 8'h5C);
    chk(fe_flag, "R5 fe set", fe_flag, 1);
    irq_en = 3'b000;
    #1 chk(!err_irq, "R10 masked", err_irq, 0);
    irq_en = 3'b001;
    #1 chk(err_irq, "R10 enabled fe", err_irq, 1);
    irq_en = 3'b110;
    #1 chk(!err_irq, "R10 other enables", err_irq, 0);
    irq_en = 3'b000;
    rd();
    clr_all();
    chk(!fe_flag, "R9 fe cleared", fe_flag, 0);
  endtask

  task automatic t_defer();
    send(8'h31, 0, 1, 0);
    send(8'h32, 0, 0, 0);
    chk(rd_data == 8'h31 && !fe_flag, "R6 flag deferred", fe_flag, 0);
    rd();
    chk(rd_data == 8'h32 && fe_flag, "R6 flag at head", fe_flag, 1);
    rd();
    clr_all();
  endtask

  task automatic t_overrun();
    send(8'h11, 0, 1, 0);
    send(8'h22, 0, 1, 0);
    send(8'h33, 0, 1, 0);
    chk(ov_flag, "R7 overrun set", ov_flag, 1);
    chk(rd_data == 8'h11, "R7 head kept", rd_data, 8'h11);
    rd();
    chk(rd_valid && rd_data == 8'h22, "R7 second kept", rd_data, 8'h22);
    rd();
    chk(!rd_valid, "R7 new byte dropped", rd_valid, 0);
    clr_all();
    chk(!ov_flag, "R9 ov cleared", ov_flag, 0);
  endtask

  task automatic t_same_cycle();
    send(8'h44, 0, 1, 0);
    send(8'h55, 0, 1, 0);
    send(8'h66, 0, 1, k0 - 1);
    chk(!ov_flag, "R8 no overrun", ov_flag, 0);
    chk(rd_valid && rd_data == 8'h55, "R8 head after read", rd_data, 8'h55);
    rd();
    chk(rd_valid && rd_data == 8'h66, "R8 new byte accepted", rd_data, 8'h66);
    rd();
    chk(!rd_valid, "R8 empty", rd_valid, 0);
  endtask

  task automatic t_empty_read();
    rd();
    chk(!rd_valid && !ov_flag, "R11 empty read ignored", rd_valid, 0);
    send(8'h9E, 0, 1, 0);
    chk(rd_valid && rd_data == 8'h9E, "R11 next byte intact", rd_data, 8'h9E);
    rd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    chk(k0 > 1, "R8 completion cycle found", k0, 2);
    t_false_start();
    t_parity();
    t_framing();
    t_defer();
    t_overrun();
    t_same_cycle();
    t_empty_read();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule